// File: doc/BRIEF.md
# Excess-3 Decimal Adder

This block adds two multi-digit decimal numbers in which every digit is held in excess-3 form, meaning each 4-bit digit carries its decimal value plus three. A carry-in of 0 or 1 enters the least significant digit. The result comes out as excess-3 digits plus a final decimal carry. A flag reports any operand digit that is not a legal excess-3 code.

Each digit cell uses two 4-bit binary adders. The first adds the two excess-3 digits and the incoming decimal carry. The carry-out of this first adder is the decimal carry of the digit, with no separate "greater than nine" test. This works because a decimal sum of ten or more pushes the biased sum to sixteen or above. The second adder corrects the raw 4-bit sum. It adds 0011 when the digit carried, and 1101 (minus three, with the carry dropped) when it did not.

Cells are chained through their decimal carries, with digit 0 as the least significant digit. The digit count is a parameter. The sum, the carry and the error flag are captured in one output register stage with a synchronous reset.

Top module: `xs3_decimal_adder`

## Requirements
- R1: A digit whose decimal value is d is encoded as d+3 on 4 bits. Legal codes run from 0011 (zero) up to 1100 (nine). Each result digit equals the excess-3 code of ((a+b+carry into that digit) mod 10), where a and b are the decimal values of the matching operand digits.
- R2: Digit i occupies bits [4i+3:4i], with digit 0 least significant. The decimal carry out of digit i enters digit i+1, so a carry can ripple across every digit.
- R3: `carry_q` is 1 exactly when the full decimal sum of the operands plus `carry_in` reaches 10^DIGITS. The remaining digits then hold that sum minus 10^DIGITS.
- R4: `carry_in` adds exactly one unit to digit 0.
- R5: `code_err_q` is 1 whenever any digit of either operand is 0000, 0001, 0010, 1101, 1110 or 1111. It is 0 when every digit is legal. Sum and carry are don't-care while it is 1.
- R6: All outputs are registered. They reflect the inputs present at the previous rising clock edge and do not change between edges.
- R7: While `rst` is high at a rising edge, every result digit becomes 0011, and `carry_q` and `code_err_q` become 0.
- R8: The largest digit case, 9+9 with a carry-in, gives digit 9 and a decimal carry of 1.
- R9: A digit sum of exactly 10 gives result digit 0 (0011) and a decimal carry of 1. A digit sum of 9 gives 9 (1100) and no carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 4*DIGITS | First operand, excess-3 digits |
| op_b | input | 4*DIGITS | Second operand, excess-3 digits |
| carry_in | input | 1 | Decimal carry into digit 0 |
| sum_q | output | 4*DIGITS | Registered excess-3 result digits |
| carry_q | output | 1 | Registered decimal carry out of the top digit |
| code_err_q | output | 1 | Registered flag for an illegal operand digit |

## Verification
The hardest case to reach is a decimal carry that must travel through every digit. It needs each intermediate digit to sum to exactly nine, so random operands almost never produce it. The stimulus reaches it on purpose with 9999+0001, with 4999+5001, and with all nines plus a carry-in. The two correction paths meet at a boundary where a digit sum of nine and a digit sum of ten sit side by side. Every pair of digits with both carry-in values is applied to digit 0 to cover it. Illegal codes are planted in an inner digit of one operand, so the flag must come from a cell other than the first.

// File: rtl/xs3_pkg.sv
package xs3_pkg;
  localparam int          DIGIT_W    = 4;
  localparam logic [3:0]  XS3_BIAS   = 4'b0011;  // +3, also the code of zero
  localparam logic [3:0]  XS3_UNBIAS = 4'b1101;  // -3 modulo 16
  localparam logic [3:0]  XS3_LO     = 4'd3;
  localparam logic [3:0]  XS3_HI     = 4'd12;

  function automatic logic xs3_ok(input logic [3:0] d);
    return (d >= XS3_LO) && (d <= XS3_HI);
  endfunction
endpackage

// File: rtl/xs3_nibble_add.sv
module xs3_nibble_add #(
  parameter int W         = 4,
  parameter bit LOOKAHEAD = 1'b1
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W-1:0] gen;
  logic [W-1:0] prop;
  logic [W:0]   c;

  assign gen  = a & b;
  assign prop = a | b;

  generate
    if (LOOKAHEAD) begin : g_cla
      // every carry is formed straight from gen/prop/cin, not from its neighbour
      always_comb begin
        logic run;
        c[0] = cin;
        for (int i = 1; i <= W; i++) begin
          run = cin;
          for (int j = 0; j < i; j++) run = gen[j] | (prop[j] & run);
          c[i] = run;
        end
      end
    end else begin : g_ripple
      assign c[0] = cin;
      for (genvar i = 0; i < W; i++) begin : g_bit
        assign c[i+1] = gen[i] | (prop[i] & c[i]);
      end
    end
  endgenerate

  assign sum  = a ^ b ^ c[W-1:0];
  assign cout = c[W];
endmodule

// File: rtl/xs3_code_check.sv
module xs3_code_check #(
  parameter int DIGITS = 4,
  localparam int W     = 4 * DIGITS
) (
  input  logic [W-1:0]      digits,
  output logic [DIGITS-1:0] bad
);
  import xs3_pkg::*;
  generate
    for (genvar i = 0; i < DIGITS; i++) begin : g_dig
      assign bad[i] = ~xs3_ok(digits[DIGIT_W*i +: DIGIT_W]);
    end
  endgenerate
endmodule

// File: rtl/xs3_digit_cell.sv
module xs3_digit_cell #(
  parameter bit LOOKAHEAD = 1'b1
) (
  input  logic [3:0] a,
  input  logic [3:0] b,
  input  logic       cin,
  output logic [3:0] digit,
  output logic       j
);
  import xs3_pkg::*;

  logic [3:0] raw;
  logic       raw_co;
  logic [3:0] corr;
  logic       fix_co;
  logic       in_ok;

  xs3_nibble_add #(.W(4), .LOOKAHEAD(LOOKAHEAD)) u_raw (
    .a(a), .b(b), .cin(cin), .sum(raw), .cout(raw_co)
  );

  // a carried digit left the bias at +6-16+... so add 3; otherwise remove 3
  assign corr = raw_co ? XS3_BIAS : XS3_UNBIAS;

  xs3_nibble_add #(.W(4), .LOOKAHEAD(LOOKAHEAD)) u_fix (
    .a(raw), .b(corr), .cin(1'b0), .sum(digit), .cout(fix_co)
  );

  assign j     = raw_co;
  assign in_ok = xs3_ok(a) && xs3_ok(b);

  always_comb begin
    if (in_ok) begin
      // R1 R9
      digit_value_chk: assert (int'(a) + int'(b) + int'(cin) - 6 ==
                               int'(digit) - 3 + (j ? 10 : 0));
      // R1
      digit_range_chk: assert (xs3_ok(digit));
      // R8 correction carry is always the opposite of the decimal carry
      fix_carry_chk: assert (fix_co == ~j);
    end
  end
endmodule

// File: rtl/xs3_decimal_adder.sv
module xs3_decimal_adder #(
  parameter int DIGITS    = 4,
  parameter bit LOOKAHEAD = 1'b1,
  localparam int W        = 4 * DIGITS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         carry_in,
  output logic [W-1:0] sum_q,
  output logic         carry_q,
  output logic         code_err_q
);
  import xs3_pkg::*;

  logic [DIGITS:0]   dcarry;
  logic [W-1:0]      sum_d;
  logic [DIGITS-1:0] bad_a;
  logic [DIGITS-1:0] bad_b;
  logic              err_d;

  assign dcarry[0] = carry_in;

  generate
    for (genvar i = 0; i < DIGITS; i++) begin : g_cell
      xs3_digit_cell #(.LOOKAHEAD(LOOKAHEAD)) u_cell (
        .a    (op_a[DIGIT_W*i +: DIGIT_W]),
        .b    (op_b[DIGIT_W*i +: DIGIT_W]),
        .cin  (dcarry[i]),
        .digit(sum_d[DIGIT_W*i +: DIGIT_W]),
        .j    (dcarry[i+1])
      );
    end
  endgenerate

  xs3_code_check #(.DIGITS(DIGITS)) u_chk_a (.digits(op_a), .bad(bad_a));
  xs3_code_check #(.DIGITS(DIGITS)) u_chk_b (.digits(op_b), .bad(bad_b));

  assign err_d = |(bad_a | bad_b);

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q      <= {DIGITS{XS3_BIAS}};
      carry_q    <= 1'b0;
      code_err_q <= 1'b0;
    end else begin
      sum_q      <= sum_d;
      carry_q    <= dcarry[DIGITS];
      code_err_q <= err_d;
    end
  end

  function automatic logic all_legal(input logic [W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < DIGITS; i++) ok = ok & xs3_ok(v[DIGIT_W*i +: DIGIT_W]);
    return ok;
  endfunction

  // R1
  out_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !code_err_q) |-> all_legal(sum_q));

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable(op_a) && $stable(op_b) && $stable(carry_in))
      |=> ($stable(sum_q) && $stable(carry_q)));

  generate
    for (genvar i = 0; i < DIGITS; i++) begin : g_errchk
      // R5
      bad_code_chk: assert property (@(posedge clk) disable iff (rst)
        (!xs3_ok(op_a[DIGIT_W*i +: DIGIT_W]) || !xs3_ok(op_b[DIGIT_W*i +: DIGIT_W]))
          |=> code_err_q);
    end
  endgenerate
endmodule

// File: tb/test_xs3_decimal_adder.sv
module test_xs3_decimal_adder;
  localparam int N = 4;
  localparam int W = 4 * N;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic         carry_in = 1'b0;
  logic [W-1:0] sum_q;
  logic         carry_q;
  logic         code_err_q;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  xs3_decimal_adder #(.DIGITS(N)) i_xs3_decimal_adder (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
    .sum_q(sum_q), .carry_q(carry_q), .code_err_q(code_err_q)
  );

  function automatic int pow10(input int n);
    int r = 1;
    for (int i = 0; i < n; i++) r = r * 10;
    return r;
  endfunction

  function automatic logic [W-1:0] enc(input int v);
    logic [W-1:0] r;
    for (int i = 0; i < N; i++) begin
      r[4*i +: 4] = 4'(v % 10 + 3);
      v = v / 10;
    end
    return r;
  endfunction

  task automatic expect_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic add_check(input string req, input int a, input int b, input bit ci);
    int s;
    @(negedge clk);
    op_a = enc(a); op_b = enc(b); carry_in = ci;
    @(negedge clk);
    s = a + b + int'(ci);
    expect_eq(req, "sum", int'(sum_q), int'(enc(s % pow10(N))));
    expect_eq(req, "carry", int'(carry_q), int'(s >= pow10(N)));
    expect_eq(req, "err", int'(code_err_q), 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    op_a = enc(4321); op_b = enc(5678); carry_in = 1'b1; rst = 1'b1;
    repeat (2) @(negedge clk);
    expect_eq("R7", "reset sum", int'(sum_q), int'(enc(0)));
    expect_eq("R7", "reset carry", int'(carry_q), 0);
    expect_eq("R7", "reset err", int'(code_err_q), 0);
    rst = 1'b0;
  endtask

  task automatic t_digit_pairs;
    for (int a = 0; a < 10; a++)
      for (int b = 0; b < 10; b++)
        for (int c = 0; c < 2; c++)
          add_check("R1 R4", a, b, c[0]);
  endtask

  task automatic t_boundaries;
    add_check("R8", 9, 9, 1'b1);
    add_check("R9", 5, 5, 1'b0);
    add_check("R9", 4, 5, 1'b0);
    add_check("R9", 4, 5, 1'b1);
    add_check("R4", 0, 0, 1'b1);
  endtask

  task automatic t_ripple;
    add_check("R2 R3", 9999, 1, 1'b0);
    add_check("R2 R3", 4999, 5001, 1'b0);
    add_check("R2 R3", 9999, 9999, 1'b1);
    add_check("R2", 999, 0, 1'b1);
    add_check("R3", 9999, 0, 1'b0);
  endtask

  task automatic t_random;
    for (int k = 0; k < 60; k++)
      add_check("R1 R2 R3", int'($urandom % 10000), int'($urandom % 10000), 1'($urandom));
  endtask

  task automatic t_bad_codes;
    logic [3:0] codes [6] = '{4'h0, 4'h1, 4'h2, 4'hD, 4'hE, 4'hF};
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      op_a = enc(1234); op_b = enc(2468); carry_in = 1'b0;
      if (k % 2 == 0) op_b[11:8] = codes[k]; else op_a[7:4] = codes[k];
      @(negedge clk);
      expect_eq("R5", "err set", int'(code_err_q), 1);
    end
    add_check("R5", 1234, 2468, 1'b0);
  endtask

  task automatic t_latency;
    @(negedge clk);
    op_a = enc(1111); op_b = enc(2222); carry_in = 1'b0;
    @(negedge clk);
    op_a = enc(5000); op_b = enc(5000);
    #1;
    expect_eq("R6", "held before edge", int'(sum_q), int'(enc(3333)));
    @(negedge clk);
    expect_eq("R6", "after edge sum", int'(sum_q), int'(enc(0)));
    expect_eq("R6", "after edge carry", int'(carry_q), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_digit_pairs();
    t_boundaries();
    t_ripple();
    t_random();
    t_bad_codes();
    t_latency();
    t_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule